// File: doc/BRIEF.md
# Parallel NOR Flash Host-Side Interface Controller

This block is a clock-sampled model of the host-facing state machine of an asynchronous parallel NOR flash. It samples chip enable, output enable, write enable and the upper (non-page) part of the address on every rising clock edge. From these it tracks five operating states plus a bus-contention state. Its outputs are a 16-bit read data bus with a separate drive enable, a data-valid flag and a state code.

A read access starts when the chip is selected with write enable high, or when the upper address changes while selected. Returned data is taken from an external array input and reported valid only after three independent delays have all run out. These are the address access time, the chip-enable access time and the output-enable time, all counted in clock cycles. Once the address has been stable for the access time plus a margin, the interface drops into automatic sleep. In that state the last read word is held even if the array input changes.

The ready/busy line of the embedded-algorithm controller passes straight through the block. The block also reports when its own interface is idle, and it combines that with the controller's busy input into a low-power indication.

Top module: `flash_host_if`

## Requirements
- R1: While `ce_n` is high (sampled at a clock edge), the state after that edge is standby (code 0), and `dq_oe`, `data_valid` and `contention_err` are 0, whatever `oe_n`, `we_n` and `addr_hi` do. After reset the state is standby.
- R2: `ready_busy_n` equals `eac_ready_n` combinationally in every state, standby included.
- R3: A clock edge that samples `ce_n` low after a high sample while `we_n` is high starts a read access. With `oe_n` high the state becomes read-with-outputs-off (code 1) and `dq_oe` stays 0.
- R4: While selected with `we_n` high and `oe_n` low, the state after the edge is random read (code 2) or sleep (code 4), and `dq_oe` is 1.
- R5: While selected with `we_n` low and `oe_n` high, the state after the edge is write (code 3) with `dq_oe` 0. This holds from read-with-outputs-off and from read. A later return of `we_n` high starts a new read access.
- R6: Counting edges from edge 0, where the starting event is sampled, `data_valid` is 1 after edge k only if the data is being driven, k minus the address-start edge is at least `T_ACC`, k minus the chip-select edge is at least `T_CE`, and k minus the output-enable fall edge is at least `T_OE`. `dq_out` then equals the array word for the current address.
- R7: While selected, a change of `addr_hi` restarts the address access timing. A change confined to the page bits, which feed only the array and not this block, restarts nothing, and `dq_out` follows the array one edge later.
- R8: When the address timer reaches `T_ACC + T_MARGIN` edges without restart, the state becomes sleep (code 4). In sleep `dq_out` holds the last captured word even if `array_data` changes. `oe_n` high turns `dq_oe` and `data_valid` off, and `oe_n` low again turns `dq_oe` on at once and `data_valid` on `T_OE` edges later.
- R9: A change of `addr_hi` sampled in sleep returns the state to code 1 or 2, and `data_valid` is 0 until the new access time has run out.
- R10: With `ce_n`, `oe_n` and `we_n` all sampled low, the state becomes contention (code 5), `contention_err` is 1 and `dq_oe` is 0.
- R11: `if_idle` is 1 exactly in standby and sleep. `low_power` is `if_idle` and not `eac_busy`, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr_hi | input | ADDR_W-PAGE_BITS | Upper address bits above the page field |
| array_data | input | DATA_W | Word read from the array at the current address |
| eac_busy | input | 1 | Embedded-algorithm controller is active |
| eac_ready_n | input | 1 | Ready/busy from the embedded-algorithm controller |
| dq_out | output | DATA_W | Read data bus value |
| dq_oe | output | 1 | Data bus drive enable (0 = high impedance) |
| data_valid | output | 1 | Read data meets all access delays |
| ready_busy_n | output | 1 | Pass-through of `eac_ready_n` |
| contention_err | output | 1 | Output and write enable both asserted |
| if_idle | output | 1 | Interface in standby or sleep |
| low_power | output | 1 | Interface idle and controller not busy |
| state_o | output | 3 | State code: 0 standby, 1 read outputs off, 2 read, 3 write, 4 sleep, 5 contention |

## Verification
The bench sweeps the output-enable fall across every offset from the chip-select edge. A design that took the first expiring delay instead of the latest would raise `data_valid` too early for late output-enable offsets. It also sweeps an upper-address change across every edge of an access, including edges after sleep has been entered. A timer that was not restarted, or a sleep state that ignored the change, would keep `data_valid` high or stay in code 4. Further directed cases cover page-bit changes during sleep, where a missing data latch shows up as `dq_out` following the array. They also cover output enable toggled during sleep, and the write and contention transitions, where a wrongly driven bus shows up as `dq_oe` high.

// File: rtl/fhi_pkg.sv
`timescale 1ns/1ps
package fhi_pkg;
  typedef enum logic [2:0] {
    FHI_STANDBY = 3'd0,
    FHI_RD_HIZ  = 3'd1,
    FHI_READ    = 3'd2,
    FHI_WRITE   = 3'd3,
    FHI_SLEEP   = 3'd4,
    FHI_CONTEND = 3'd5
  } fhi_state_e;
endpackage

// File: rtl/fhi_rst_sync.sv
`timescale 1ns/1ps
module fhi_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/fhi_edge_mon.sv
`timescale 1ns/1ps
module fhi_edge_mon #(
  parameter int HI_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ce_n,
  input  logic            oe_n,
  input  logic            we_n,
  input  logic [HI_W-1:0] addr_hi,
  output logic            oe_n_q,
  output logic            ce_fall,
  output logic            oe_fall,
  output logic            access_start
);
  logic            ce_n_q;
  logic            we_n_q;
  logic [HI_W-1:0] addr_q;
  logic            we_rise;
  logic            hi_chg;

  // previous-sample registers, always enabled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_n_q <= 1'b1;
      oe_n_q <= 1'b1;
      we_n_q <= 1'b1;
      addr_q <= '0;
    end else begin
      ce_n_q <= ce_n;
      oe_n_q <= oe_n;
      we_n_q <= we_n;
      addr_q <= addr_hi;
    end
  end

  always_comb begin
    ce_fall      = ce_n_q & ~ce_n;
    oe_fall      = oe_n_q & ~oe_n;
    we_rise      = ~we_n_q & we_n;
    hi_chg       = (addr_q != addr_hi);
    access_start = ~ce_n & ((ce_fall & we_n) | (hi_chg & we_n) | we_rise);
  end
endmodule

// File: rtl/fhi_sat_timer.sv
`timescale 1ns/1ps
module fhi_sat_timer #(
  parameter int CNT_W = 4,
  parameter int LIMIT = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] LIM_V = CNT_W'(LIMIT);

  logic at_lim;

  always_comb begin
    at_lim = (cnt_q == LIM_V);
    if (clr)         cnt_nxt = '0;
    else if (at_lim) cnt_nxt = cnt_q;
    else             cnt_nxt = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/fhi_fsm.sv
`timescale 1ns/1ps
module fhi_fsm
  import fhi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_n,
  input  logic       oe_n,
  input  logic       we_n,
  input  logic       access_start,
  input  logic       sleep_due,
  output fhi_state_e state_q,
  output fhi_state_e state_nxt
);
  fhi_state_e read_kind;

  always_comb begin
    read_kind = oe_n ? FHI_RD_HIZ : FHI_READ;
    if (ce_n) begin
      state_nxt = FHI_STANDBY;
    end else if (!oe_n && !we_n) begin
      state_nxt = FHI_CONTEND;
    end else if (!we_n) begin
      state_nxt = FHI_WRITE;
    end else if (access_start) begin
      state_nxt = read_kind;
    end else begin
      case (state_q)
        FHI_STANDBY, FHI_WRITE, FHI_CONTEND: state_nxt = read_kind;
        FHI_SLEEP:                           state_nxt = FHI_SLEEP;
        default: state_nxt = sleep_due ? FHI_SLEEP : read_kind;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= FHI_STANDBY;
    else        state_q <= state_nxt;
  end
endmodule

// File: rtl/fhi_datapath.sv
`timescale 1ns/1ps
module fhi_datapath
  import fhi_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fhi_state_e        state_q,
  input  fhi_state_e        state_nxt,
  input  logic              oe_n_q,
  input  logic              timers_done,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              data_valid,
  output logic              contention_err,
  output logic              if_idle
);
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] data_d;
  logic              cap_en;

  // capture only while an active read is next; sleep and others hold
  always_comb begin
    cap_en = (state_nxt == FHI_READ) || (state_nxt == FHI_RD_HIZ);
    data_d = cap_en ? array_data : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else        data_q <= data_d;
  end

  always_comb begin
    dq_out         = data_q;
    dq_oe          = (state_q == FHI_READ) || ((state_q == FHI_SLEEP) && !oe_n_q);
    data_valid     = dq_oe && timers_done;
    contention_err = (state_q == FHI_CONTEND);
    if_idle        = (state_q == FHI_STANDBY) || (state_q == FHI_SLEEP);
  end
endmodule

// File: rtl/flash_host_if.sv
`timescale 1ns/1ps
module flash_host_if
  import fhi_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int PAGE_BITS = 4,
  parameter int DATA_W    = 16,
  parameter int T_ACC     = 6,
  parameter int T_CE      = 5,
  parameter int T_OE      = 2,
  parameter int T_MARGIN  = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ce_n,
  input  logic                        oe_n,
  input  logic                        we_n,
  input  logic [ADDR_W-PAGE_BITS-1:0] addr_hi,
  input  logic [DATA_W-1:0]           array_data,
  input  logic                        eac_busy,
  input  logic                        eac_ready_n,
  output logic [DATA_W-1:0]           dq_out,
  output logic                        dq_oe,
  output logic                        data_valid,
  output logic                        ready_busy_n,
  output logic                        contention_err,
  output logic                        if_idle,
  output logic                        low_power,
  output logic [2:0]                  state_o
);
  localparam int HI_W   = ADDR_W - PAGE_BITS;
  localparam int SAT    = T_ACC + T_MARGIN;
  localparam int MAX_A  = (SAT > T_CE) ? SAT : T_CE;
  localparam int MAX_L  = (MAX_A > T_OE) ? MAX_A : T_OE;
  localparam int CNT_W  = $clog2(MAX_L + 1);
  localparam int N_TMR  = 3;
  localparam int TI_ADR = 0;
  localparam int TI_CE  = 1;
  localparam int TI_OE  = 2;

  function automatic int tmr_limit(input int idx);
    case (idx)
      TI_ADR:  return SAT;
      TI_CE:   return T_CE;
      default: return T_OE;
    endcase
  endfunction

  logic             rst_sync_n;
  logic             oe_n_q;
  logic             ce_fall;
  logic             oe_fall;
  logic             access_start;
  logic [N_TMR-1:0] tmr_clr;
  logic [CNT_W-1:0] tmr_q   [N_TMR];
  logic [CNT_W-1:0] tmr_nxt [N_TMR];
  logic             sleep_due;
  logic             timers_done;
  fhi_state_e       state_q;
  fhi_state_e       state_nxt;

  fhi_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fhi_edge_mon #(.HI_W(HI_W)) u_edge_mon (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .ce_n         (ce_n),
    .oe_n         (oe_n),
    .we_n         (we_n),
    .addr_hi      (addr_hi),
    .oe_n_q       (oe_n_q),
    .ce_fall      (ce_fall),
    .oe_fall      (oe_fall),
    .access_start (access_start)
  );

  assign tmr_clr[TI_ADR] = access_start;
  assign tmr_clr[TI_CE]  = ce_fall;
  assign tmr_clr[TI_OE]  = oe_fall;

  for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
    fhi_sat_timer #(.CNT_W(CNT_W), .LIMIT(tmr_limit(g))) u_tmr (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .clr     (tmr_clr[g]),
      .cnt_nxt (tmr_nxt[g]),
      .cnt_q   (tmr_q[g])
    );
  end

  always_comb begin
    sleep_due   = (tmr_nxt[TI_ADR] == CNT_W'(SAT));
    timers_done = (tmr_q[TI_ADR] >= CNT_W'(T_ACC)) &&
                  (tmr_q[TI_CE]  >= CNT_W'(T_CE))  &&
                  (tmr_q[TI_OE]  >= CNT_W'(T_OE));
  end

  fhi_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .ce_n         (ce_n),
    .oe_n         (oe_n),
    .we_n         (we_n),
    .access_start (access_start),
    .sleep_due    (sleep_due),
    .state_q      (state_q),
    .state_nxt    (state_nxt)
  );

  fhi_datapath #(.DATA_W(DATA_W)) u_datapath (
    .clk            (clk),
    .rst_n          (rst_sync_n),
    .state_q        (state_q),
    .state_nxt      (state_nxt),
    .oe_n_q         (oe_n_q),
    .timers_done    (timers_done),
    .array_data     (array_data),
    .dq_out         (dq_out),
    .dq_oe          (dq_oe),
    .data_valid     (data_valid),
    .contention_err (contention_err),
    .if_idle        (if_idle)
  );

  always_comb begin
    ready_busy_n = eac_ready_n;
    low_power    = if_idle & ~eac_busy;
    state_o      = state_q;
  end
endmodule

// File: rtl/fhi_checker.sv
`timescale 1ns/1ps
module fhi_checker #(
  parameter int HI_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ce_n,
  input logic            oe_n,
  input logic            we_n,
  input logic [HI_W-1:0] addr_hi,
  input logic            dq_oe,
  input logic            data_valid,
  input logic            contention_err,
  input logic            low_power,
  input logic            eac_busy,
  input logic [2:0]      state_o
);
  logic hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= 1'b0;
    else        hist_q <= 1'b1;
  end

  assert_standby_hiz_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> (state_o == 3'd0 && !dq_oe && !data_valid));

  assert_rd_hiz_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && we_n && oe_n) |=> (!dq_oe && state_o != 3'd3));

  assert_read_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && we_n && !oe_n) |=> dq_oe);

  assert_write_hiz_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !we_n && oe_n) |=> (state_o == 3'd3 && !dq_oe));

  assert_no_early_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_q && $fell(ce_n)) |=> !data_valid);

  assert_sleep_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_q && state_o == 3'd4 && !ce_n && we_n && addr_hi != $past(addr_hi))
      |=> (state_o != 3'd4 && !data_valid));

  assert_contend_hiz_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !we_n && !oe_n) |=> (contention_err && !dq_oe));

  assert_low_power_R11: assert property (@(posedge clk) disable iff (!rst_n)
    low_power |-> !eac_busy);
endmodule

bind flash_host_if fhi_checker #(.HI_W(ADDR_W - PAGE_BITS)) u_fhi_checker (
  .clk            (clk),
  .rst_n          (rst_sync_n),
  .ce_n           (ce_n),
  .oe_n           (oe_n),
  .we_n           (we_n),
  .addr_hi        (addr_hi),
  .dq_oe          (dq_oe),
  .data_valid     (data_valid),
  .contention_err (contention_err),
  .low_power      (low_power),
  .eac_busy       (eac_busy),
  .state_o        (state_o)
);

// File: tb/tb_flash_host_if.sv
`timescale 1ns/1ps
module tb_flash_host_if;
  localparam int ADDR_W = 8;
  localparam int PB     = 4;
  localparam int DW     = 16;
  localparam int T_ACC  = 6;
  localparam int T_CE   = 5;
  localparam int T_OE   = 2;
  localparam int T_MRG  = 3;
  localparam int SAT    = T_ACC + T_MRG;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              ce_n, oe_n, we_n;
  logic [ADDR_W-1:0] addr;
  logic [DW-1:0]     array_data;
  logic              eac_busy, eac_ready_n;
  logic [DW-1:0]     dq_out;
  logic              dq_oe, data_valid, ready_busy_n, contention_err, if_idle, low_power;
  logic [2:0]        state_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  function automatic logic [DW-1:0] fdat(input logic [ADDR_W-1:0] a);
    return {a, ~a} ^ 16'h5A3C;
  endfunction

  assign array_data = fdat(addr);

  flash_host_if #(.ADDR_W(ADDR_W), .PAGE_BITS(PB), .DATA_W(DW), .T_ACC(T_ACC),
                  .T_CE(T_CE), .T_OE(T_OE), .T_MARGIN(T_MRG)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr_hi(addr[ADDR_W-1:PB]), .array_data(array_data), .eac_busy(eac_busy),
    .eac_ready_n(eac_ready_n), .dq_out(dq_out), .dq_oe(dq_oe), .data_valid(data_valid),
    .ready_busy_n(ready_busy_n), .contention_err(contention_err), .if_idle(if_idle),
    .low_power(low_power), .state_o(state_o));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic deselect(input int n);
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; addr = '0;
    eac_busy = 1'b0; eac_ready_n = 1'b1;
    for (int i = 0; i < 3; i++) step();
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step();
    chk("R1 reset state", state_o, 0);
    chk("R1 reset dq_oe", dq_oe, 0);
    chk("R1 reset valid", data_valid, 0);

    // R1: standby ignores everything
    for (int i = 0; i < 8; i++) begin
      oe_n = i[0]; we_n = i[1]; addr = 8'(i * 37);
      step();
      chk("R1 standby state", state_o, 0);
      chk("R1 standby dq_oe", dq_oe, 0);
      chk("R1 standby valid", data_valid, 0);
      chk("R1 standby contention", contention_err, 0);
    end

    // R2 pass-through, R11 low power in standby
    deselect(1);
    eac_ready_n = 1'b0; #1;
    chk("R2 rdy standby low", ready_busy_n, 0);
    eac_ready_n = 1'b1; #1;
    chk("R2 rdy standby high", ready_busy_n, 1);
    chk("R11 standby idle", if_idle, 1);
    chk("R11 standby lp", low_power, 1);
    eac_busy = 1'b1; #1;
    chk("R11 standby busy lp", low_power, 0);
    eac_busy = 1'b0; #1;

    // R3 R4 R6 R8: sweep output-enable fall offset
    for (int d = 0; d <= 8; d++) begin
      deselect(2);
      addr = 8'((d + 1) * 16 + 5);
      for (int k = 0; k <= 12; k++) begin
        if (k == 0) ce_n = 1'b0;
        if (k == d) oe_n = 1'b0;
        step();
        begin
          int  es;
          bit  ev;
          es = (k >= SAT) ? 4 : ((k >= d) ? 2 : 1);
          ev = (k >= d) && (k >= T_ACC) && (k >= T_CE) && ((k - d) >= T_OE);
          chk((k >= SAT) ? "R8 sweep state" : ((k >= d) ? "R4 sweep state" : "R3 sweep state"),
              state_o, es);
          chk((k >= d) ? "R4 sweep dq_oe" : "R3 sweep dq_oe", dq_oe, (k >= d) ? 1 : 0);
          chk("R6 sweep valid", data_valid, ev);
          if (ev) chk("R6 sweep data", dq_out, fdat(addr));
        end
      end
    end

    // R7 R9: sweep the edge of an upper-address change
    for (int a = 1; a <= 11; a++) begin
      deselect(2);
      addr = 8'h10;
      for (int k = 0; k <= 14; k++) begin
        if (k == 0) begin ce_n = 1'b0; oe_n = 1'b0; end
        if (k == a) addr = 8'hA7;
        step();
        begin
          int kk;
          bit ev;
          kk = (k < a) ? k : k - a;
          ev = (kk >= T_ACC) && (k >= T_CE) && (k >= T_OE);
          chk((k >= a) ? "R9 addr sweep state" : "R7 addr sweep state", state_o, (kk >= SAT) ? 4 : 2);
          chk("R7 addr sweep valid", data_valid, ev);
          if (ev) chk("R7 addr sweep data", dq_out, fdat(addr));
        end
      end
    end

    // R7 page-bit change, R8 latch and oe control, R9 wake
    deselect(2);
    addr = 8'h40;
    ce_n = 1'b0; oe_n = 1'b0;
    for (int k = 0; k <= 7; k++) step();
    chk("R6 page start valid", data_valid, 1);
    addr = 8'h4B;
    step();                                   // edge 8
    chk("R7 page state", state_o, 2);
    chk("R7 page valid", data_valid, 1);
    chk("R7 page data", dq_out, fdat(8'h4B));
    step();                                   // edge 9
    chk("R8 sleep entry", state_o, 4);
    chk("R11 sleep idle", if_idle, 1);
    chk("R11 sleep lp", low_power, 1);
    eac_busy = 1'b1; #1;
    chk("R11 sleep busy lp", low_power, 0);
    eac_busy = 1'b0;
    eac_ready_n = 1'b0; #1;
    chk("R2 rdy selected", ready_busy_n, 0);
    eac_ready_n = 1'b1;
    addr = 8'h4E;
    step();
    chk("R8 latch state", state_o, 4);
    chk("R8 latch data", dq_out, fdat(8'h4B));
    chk("R8 latch valid", data_valid, 1);
    oe_n = 1'b1;
    step();
    chk("R8 oe off state", state_o, 4);
    chk("R8 oe off dq_oe", dq_oe, 0);
    chk("R8 oe off valid", data_valid, 0);
    oe_n = 1'b0;
    for (int k = 0; k <= T_OE; k++) begin
      step();
      chk("R8 oe on dq_oe", dq_oe, 1);
      chk("R8 oe on valid", data_valid, (k >= T_OE) ? 1 : 0);
    end
    addr = 8'h5E;
    step();
    chk("R9 wake state", state_o, 2);
    chk("R9 wake valid", data_valid, 0);
    for (int k = 1; k <= T_ACC; k++) begin
      step();
      chk("R9 wake timing", data_valid, (k >= T_ACC) ? 1 : 0);
    end
    chk("R9 wake data", dq_out, fdat(8'h5E));
    chk("R11 read not idle", low_power, 0);

    // R5 R10: write and contention paths
    deselect(2);
    addr = 8'h33;
    ce_n = 1'b0;
    step(); step();
    chk("R3 rd hiz", state_o, 1);
    we_n = 1'b0;
    step();
    chk("R5 write from rd hiz", state_o, 3);
    chk("R5 write dq_oe", dq_oe, 0);
    oe_n = 1'b0;
    step();
    chk("R10 contention state", state_o, 5);
    chk("R10 contention flag", contention_err, 1);
    chk("R10 contention dq_oe", dq_oe, 0);
    oe_n = 1'b1;
    step();
    chk("R5 back to write", state_o, 3);
    chk("R10 flag clears", contention_err, 0);
    we_n = 1'b1;
    step();
    chk("R5 new read state", state_o, 1);
    oe_n = 1'b0;
    for (int k = 1; k <= T_ACC; k++) step();
    chk("R5 new read valid", data_valid, 1);
    oe_n = 1'b1; we_n = 1'b0;
    step();
    chk("R5 write from read", state_o, 3);
    chk("R5 write from read dq_oe", dq_oe, 0);

    // R5: select with write enable already low
    deselect(2);
    we_n = 1'b0; ce_n = 1'b0;
    step();
    chk("R5 select in write", state_o, 3);
    we_n = 1'b1;
    step();
    chk("R3 read after write", state_o, 1);

    deselect(2);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule